// File: doc/BRIEF.md
# AXI In-Flight Transaction Limiter

This block sits between an AXI3-style requester and the downstream interconnect. It puts a ceiling on how many write transactions and how many read transactions may be open at once. Two independent counters track the open transactions. A write is opened by an accepted write-address handshake and closed by an accepted write-response handshake. A read is opened by an accepted read-address handshake and closed only by an accepted read-data beat that carries the last-beat flag.

When a counter sits at its ceiling, the block throttles that address channel only. It masks the valid going downstream and the ready going back upstream. The other direction keeps running. The write-data channel, the response channels and every payload field pass straight through.

If a retirement and a new request of the same kind land in the same cycle while the counter is at its ceiling, the request is admitted and the count holds. The current counts and the at-ceiling flags are brought out so the block can be observed.

Top module: `axi_inflight_limiter`

## Requirements
- R1: While rst_ni is low and after it is released, wr_cnt_o and rd_cnt_o are 0 and wr_full_o and rd_full_o are low.
- R2: wr_cnt_o rises by one after a cycle with an accepted write-address handshake (m_awvalid_o and m_awready_i) and no accepted write response. It falls by one after a cycle with an accepted write response (m_bvalid_i and s_bready_i) and no address handshake. It holds when both happen in the same cycle.
- R3: rd_cnt_o rises by one after an accepted read-address handshake. It falls by one only after an accepted read beat with m_rlast_i high (m_rvalid_i and s_rready_i). Accepted beats with m_rlast_i low leave it unchanged.
- R4: Below the ceiling, m_awvalid_o equals s_awvalid_i and s_awready_o equals m_awready_i. The read address channel behaves the same way, so addresses can issue back to back without waiting for responses.
- R5: When a count equals its ceiling and no retirement of that kind is accepted in the same cycle, that channel's downstream valid and upstream ready are both low.
- R6: When a count equals its ceiling and a retirement of that kind is accepted in the same cycle, that channel's valid and ready pass through as in R4.
- R7: wr_full_o is high exactly when wr_cnt_o equals WR_MAX. rd_full_o is high exactly when rd_cnt_o equals RD_MAX.
- R8: The counts never exceed their ceilings. A retirement accepted while a count is 0, with no request in the same cycle, leaves it at 0.
- R9: All address payload fields, the whole write-data channel, and the response and read-data channels pass through unchanged.
- R10: The write and read limits act independently. A write count at its ceiling never blocks read addresses, and a read count at its ceiling never blocks write addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_awid_i | input | 1 | Upstream write ID |
| s_awaddr_i | input | 36 | Upstream write address |
| s_awlen_i | input | 4 | Upstream write burst length |
| s_awsize_i | input | 3 | Upstream write beat size |
| s_awburst_i | input | 2 | Upstream write burst type |
| s_awlock_i | input | 2 | Upstream write lock |
| s_awcache_i | input | 4 | Upstream write cache attributes |
| s_awprot_i | input | 3 | Upstream write protection |
| s_awvalid_i | input | 1 | Upstream write address valid |
| s_awready_o | output | 1 | Upstream write address ready (gated) |
| m_awid_o | output | 1 | Downstream write ID |
| m_awaddr_o | output | 36 | Downstream write address |
| m_awlen_o | output | 4 | Downstream write burst length |
| m_awsize_o | output | 3 | Downstream write beat size |
| m_awburst_o | output | 2 | Downstream write burst type |
| m_awlock_o | output | 2 | Downstream write lock |
| m_awcache_o | output | 4 | Downstream write cache attributes |
| m_awprot_o | output | 3 | Downstream write protection |
| m_awvalid_o | output | 1 | Downstream write address valid (gated) |
| m_awready_i | input | 1 | Downstream write address ready |
| s_wid_i | input | 1 | Upstream write data ID |
| s_wdata_i | input | 256 | Upstream write data |
| s_wstrb_i | input | 32 | Upstream write strobes |
| s_wlast_i | input | 1 | Upstream last write beat |
| s_wvalid_i | input | 1 | Upstream write data valid |
| s_wready_o | output | 1 | Upstream write data ready |
| m_wid_o | output | 1 | Downstream write data ID |
| m_wdata_o | output | 256 | Downstream write data |
| m_wstrb_o | output | 32 | Downstream write strobes |
| m_wlast_o | output | 1 | Downstream last write beat |
| m_wvalid_o | output | 1 | Downstream write data valid |
| m_wready_i | input | 1 | Downstream write data ready |
| m_bid_i | input | 1 | Downstream response ID |
| m_bresp_i | input | 2 | Downstream response code |
| m_bvalid_i | input | 1 | Downstream response valid |
| m_bready_o | output | 1 | Downstream response ready |
| s_bid_o | output | 1 | Upstream response ID |
| s_bresp_o | output | 2 | Upstream response code |
| s_bvalid_o | output | 1 | Upstream response valid |
| s_bready_i | input | 1 | Upstream response ready |
| s_arid_i | input | 1 | Upstream read ID |
| s_araddr_i | input | 36 | Upstream read address |
| s_arlen_i | input | 4 | Upstream read burst length |
| s_arsize_i | input | 3 | Upstream read beat size |
| s_arburst_i | input | 2 | Upstream read burst type |
| s_arlock_i | input | 2 | Upstream read lock |
| s_arcache_i | input | 4 | Upstream read cache attributes |
| s_arprot_i | input | 3 | Upstream read protection |
| s_arvalid_i | input | 1 | Upstream read address valid |
| s_arready_o | output | 1 | Upstream read address ready (gated) |
| m_arid_o | output | 1 | Downstream read ID |
| m_araddr_o | output | 36 | Downstream read address |
| m_arlen_o | output | 4 | Downstream read burst length |
| m_arsize_o | output | 3 | Downstream read beat size |
| m_arburst_o | output | 2 | Downstream read burst type |
| m_arlock_o | output | 2 | Downstream read lock |
| m_arcache_o | output | 4 | Downstream read cache attributes |
| m_arprot_o | output | 3 | Downstream read protection |
| m_arvalid_o | output | 1 | Downstream read address valid (gated) |
| m_arready_i | input | 1 | Downstream read address ready |
| m_rid_i | input | 1 | Downstream read data ID |
| m_rdata_i | input | 256 | Downstream read data |
| m_rresp_i | input | 2 | Downstream read response |
| m_rlast_i | input | 1 | Downstream last read beat |
| m_rvalid_i | input | 1 | Downstream read data valid |
| m_rready_o | output | 1 | Downstream read data ready |
| s_rid_o | output | 1 | Upstream read data ID |
| s_rdata_o | output | 256 | Upstream read data |
| s_rresp_o | output | 2 | Upstream read response |
| s_rlast_o | output | 1 | Upstream last read beat |
| s_rvalid_o | output | 1 | Upstream read data valid |
| s_rready_i | input | 1 | Upstream read data ready |
| wr_cnt_o | output | $clog2(WR_MAX+1) | Open write count |
| rd_cnt_o | output | $clog2(RD_MAX+1) | Open read count |
| wr_full_o | output | 1 | Write count at ceiling |
| rd_full_o | output | 1 | Read count at ceiling |

## Verification
The hardest case to reach from the ports is a counter sitting at its ceiling while a retirement and a pending address request arrive in the same cycle. In that cycle the gate must open, and the count must then hold rather than step. The bench uses small ceilings of 3 writes and 2 reads. It holds address requests pending most of the time and drives responses and last-beat flags from a pseudo-random pattern over thousands of cycles, so both counters spend long stretches at their ceilings and this coincidence recurs many times. The random pattern also produces non-last read beats and responses that arrive while a count is zero. Every gate and count output is compared each cycle against an arithmetic model.

// File: rtl/axi_lim_pkg.sv
package axi_lim_pkg;
  localparam int unsigned ID_W    = 1;
  localparam int unsigned ADDR_W  = 36;
  localparam int unsigned LEN_W   = 4;
  localparam int unsigned SIZE_W  = 3;
  localparam int unsigned BURST_W = 2;
  localparam int unsigned LOCK_W  = 2;
  localparam int unsigned CACHE_W = 4;
  localparam int unsigned PROT_W  = 3;
  localparam int unsigned RESP_W  = 2;
  localparam int unsigned DATA_W  = 256;
  localparam int unsigned STRB_W  = DATA_W / 8;

  typedef struct packed {
    logic [ID_W-1:0]    id;
    logic [ADDR_W-1:0]  addr;
    logic [LEN_W-1:0]   len;
    logic [SIZE_W-1:0]  size;
    logic [BURST_W-1:0] burst;
    logic [LOCK_W-1:0]  lock;
    logic [CACHE_W-1:0] cache;
    logic [PROT_W-1:0]  prot;
  } addr_cmd_t;
endpackage

// File: rtl/inflight_ctr.sv
module inflight_ctr #(
  parameter  int unsigned MAX   = 5,
  localparam int unsigned CNT_W = $clog2(MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             allow_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dec_eff;

  assign full_o  = (cnt_q == CNT_W'(MAX));
  // at ceiling cnt_q != 0, so a retirement is always effective there
  assign allow_o = !full_o || dec_i;
  assign dec_eff = dec_i && ((cnt_q != '0) || inc_i);
  assign cnt_o   = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i && !dec_eff)      cnt_d = cnt_q + 1'b1;
    else if (!inc_i && dec_eff) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX));
  // R8
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !inc_i) |=> cnt_q == '0);
  // R2
  both_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && dec_i) |=> $stable(cnt_q));
  // R2
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/addr_gate.sv
module addr_gate
  import axi_lim_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      allow_i,
  input  addr_cmd_t up_cmd_i,
  input  logic      up_valid_i,
  output logic      up_ready_o,
  output addr_cmd_t dn_cmd_o,
  output logic      dn_valid_o,
  input  logic      dn_ready_i,
  output logic      fire_o
);
  assign dn_cmd_o   = up_cmd_i;
  assign dn_valid_o = up_valid_i && allow_i;
  assign up_ready_o = dn_ready_i && allow_i;
  assign fire_o     = dn_valid_o && dn_ready_i;

  // R5
  gate_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !allow_i |-> (!dn_valid_o && !up_ready_o));
  // R4
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_valid_o && !dn_ready_i) |=> dn_valid_o);
endmodule

// File: rtl/axi_inflight_limiter.sv
module axi_inflight_limiter
  import axi_lim_pkg::*;
#(
  parameter  int unsigned WR_MAX   = 5,
  parameter  int unsigned RD_MAX   = 5,
  localparam int unsigned WR_CNT_W = $clog2(WR_MAX + 1),
  localparam int unsigned RD_CNT_W = $clog2(RD_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ID_W-1:0]     s_awid_i,
  input  logic [ADDR_W-1:0]   s_awaddr_i,
  input  logic [LEN_W-1:0]    s_awlen_i,
  input  logic [SIZE_W-1:0]   s_awsize_i,
  input  logic [BURST_W-1:0]  s_awburst_i,
  input  logic [LOCK_W-1:0]   s_awlock_i,
  input  logic [CACHE_W-1:0]  s_awcache_i,
  input  logic [PROT_W-1:0]   s_awprot_i,
  input  logic                s_awvalid_i,
  output logic                s_awready_o,
  output logic [ID_W-1:0]     m_awid_o,
  output logic [ADDR_W-1:0]   m_awaddr_o,
  output logic [LEN_W-1:0]    m_awlen_o,
  output logic [SIZE_W-1:0]   m_awsize_o,
  output logic [BURST_W-1:0]  m_awburst_o,
  output logic [LOCK_W-1:0]   m_awlock_o,
  output logic [CACHE_W-1:0]  m_awcache_o,
  output logic [PROT_W-1:0]   m_awprot_o,
  output logic                m_awvalid_o,
  input  logic                m_awready_i,
  input  logic [ID_W-1:0]     s_wid_i,
  input  logic [DATA_W-1:0]   s_wdata_i,
  input  logic [STRB_W-1:0]   s_wstrb_i,
  input  logic                s_wlast_i,
  input  logic                s_wvalid_i,
  output logic                s_wready_o,
  output logic [ID_W-1:0]     m_wid_o,
  output logic [DATA_W-1:0]   m_wdata_o,
  output logic [STRB_W-1:0]   m_wstrb_o,
  output logic                m_wlast_o,
  output logic                m_wvalid_o,
  input  logic                m_wready_i,
  input  logic [ID_W-1:0]     m_bid_i,
  input  logic [RESP_W-1:0]   m_bresp_i,
  input  logic                m_bvalid_i,
  output logic                m_bready_o,
  output logic [ID_W-1:0]     s_bid_o,
  output logic [RESP_W-1:0]   s_bresp_o,
  output logic                s_bvalid_o,
  input  logic                s_bready_i,
  input  logic [ID_W-1:0]     s_arid_i,
  input  logic [ADDR_W-1:0]   s_araddr_i,
  input  logic [LEN_W-1:0]    s_arlen_i,
  input  logic [SIZE_W-1:0]   s_arsize_i,
  input  logic [BURST_W-1:0]  s_arburst_i,
  input  logic [LOCK_W-1:0]   s_arlock_i,
  input  logic [CACHE_W-1:0]  s_arcache_i,
  input  logic [PROT_W-1:0]   s_arprot_i,
  input  logic                s_arvalid_i,
  output logic                s_arready_o,
  output logic [ID_W-1:0]     m_arid_o,
  output logic [ADDR_W-1:0]   m_araddr_o,
  output logic [LEN_W-1:0]    m_arlen_o,
  output logic [SIZE_W-1:0]   m_arsize_o,
  output logic [BURST_W-1:0]  m_arburst_o,
  output logic [LOCK_W-1:0]   m_arlock_o,
  output logic [CACHE_W-1:0]  m_arcache_o,
  output logic [PROT_W-1:0]   m_arprot_o,
  output logic                m_arvalid_o,
  input  logic                m_arready_i,
  input  logic [ID_W-1:0]     m_rid_i,
  input  logic [DATA_W-1:0]   m_rdata_i,
  input  logic [RESP_W-1:0]   m_rresp_i,
  input  logic                m_rlast_i,
  input  logic                m_rvalid_i,
  output logic                m_rready_o,
  output logic [ID_W-1:0]     s_rid_o,
  output logic [DATA_W-1:0]   s_rdata_o,
  output logic [RESP_W-1:0]   s_rresp_o,
  output logic                s_rlast_o,
  output logic                s_rvalid_o,
  input  logic                s_rready_i,
  output logic [WR_CNT_W-1:0] wr_cnt_o,
  output logic [RD_CNT_W-1:0] rd_cnt_o,
  output logic                wr_full_o,
  output logic                rd_full_o
);
  addr_cmd_t aw_up, aw_dn, ar_up, ar_dn;
  logic      wr_allow, rd_allow, aw_fire, ar_fire, wr_retire, rd_retire;

  assign aw_up = '{id: s_awid_i, addr: s_awaddr_i, len: s_awlen_i, size: s_awsize_i,
                   burst: s_awburst_i, lock: s_awlock_i, cache: s_awcache_i, prot: s_awprot_i};
  assign ar_up = '{id: s_arid_i, addr: s_araddr_i, len: s_arlen_i, size: s_arsize_i,
                   burst: s_arburst_i, lock: s_arlock_i, cache: s_arcache_i, prot: s_arprot_i};

  assign m_awid_o    = aw_dn.id;
  assign m_awaddr_o  = aw_dn.addr;
  assign m_awlen_o   = aw_dn.len;
  assign m_awsize_o  = aw_dn.size;
  assign m_awburst_o = aw_dn.burst;
  assign m_awlock_o  = aw_dn.lock;
  assign m_awcache_o = aw_dn.cache;
  assign m_awprot_o  = aw_dn.prot;
  assign m_arid_o    = ar_dn.id;
  assign m_araddr_o  = ar_dn.addr;
  assign m_arlen_o   = ar_dn.len;
  assign m_arsize_o  = ar_dn.size;
  assign m_arburst_o = ar_dn.burst;
  assign m_arlock_o  = ar_dn.lock;
  assign m_arcache_o = ar_dn.cache;
  assign m_arprot_o  = ar_dn.prot;

  // write data channel: untouched
  assign m_wid_o    = s_wid_i;
  assign m_wdata_o  = s_wdata_i;
  assign m_wstrb_o  = s_wstrb_i;
  assign m_wlast_o  = s_wlast_i;
  assign m_wvalid_o = s_wvalid_i;
  assign s_wready_o = m_wready_i;

  // response channels: untouched
  assign s_bid_o    = m_bid_i;
  assign s_bresp_o  = m_bresp_i;
  assign s_bvalid_o = m_bvalid_i;
  assign m_bready_o = s_bready_i;
  assign s_rid_o    = m_rid_i;
  assign s_rdata_o  = m_rdata_i;
  assign s_rresp_o  = m_rresp_i;
  assign s_rlast_o  = m_rlast_i;
  assign s_rvalid_o = m_rvalid_i;
  assign m_rready_o = s_rready_i;

  assign wr_retire = m_bvalid_i && s_bready_i;
  assign rd_retire = m_rvalid_i && s_rready_i && m_rlast_i;

  addr_gate i_aw_gate (
    .clk_i, .rst_ni, .allow_i(wr_allow),
    .up_cmd_i(aw_up), .up_valid_i(s_awvalid_i), .up_ready_o(s_awready_o),
    .dn_cmd_o(aw_dn), .dn_valid_o(m_awvalid_o), .dn_ready_i(m_awready_i),
    .fire_o(aw_fire)
  );

  addr_gate i_ar_gate (
    .clk_i, .rst_ni, .allow_i(rd_allow),
    .up_cmd_i(ar_up), .up_valid_i(s_arvalid_i), .up_ready_o(s_arready_o),
    .dn_cmd_o(ar_dn), .dn_valid_o(m_arvalid_o), .dn_ready_i(m_arready_i),
    .fire_o(ar_fire)
  );

  inflight_ctr #(.MAX(WR_MAX)) i_wr_ctr (
    .clk_i, .rst_ni, .inc_i(aw_fire), .dec_i(wr_retire),
    .cnt_o(wr_cnt_o), .full_o(wr_full_o), .allow_o(wr_allow)
  );

  inflight_ctr #(.MAX(RD_MAX)) i_rd_ctr (
    .clk_i, .rst_ni, .inc_i(ar_fire), .dec_i(rd_retire),
    .cnt_o(rd_cnt_o), .full_o(rd_full_o), .allow_o(rd_allow)
  );

  // R3
  nonlast_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_rvalid_i && s_rready_i && !m_rlast_i && !ar_fire) |=> $stable(rd_cnt_o));
  // R10
  rd_indep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_full_o && !rd_full_o) |-> (m_arvalid_o == s_arvalid_i));
  // R6
  wr_admit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_full_o && wr_retire) |-> (s_awready_o == m_awready_i));
endmodule

// File: tb/test_axi_inflight_limiter.sv
`timescale 1ns/1ps
module test_axi_inflight_limiter;
  localparam int W = 3;
  localparam int R = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic [0:0]   s_awid_i = '0, m_awid_o, s_arid_i = '0, m_arid_o;
  logic [35:0]  s_awaddr_i = '0, m_awaddr_o, s_araddr_i = '0, m_araddr_o;
  logic [3:0]   s_awlen_i = '0, m_awlen_o, s_arlen_i = '0, m_arlen_o;
  logic [2:0]   s_awsize_i = '0, m_awsize_o, s_arsize_i = '0, m_arsize_o;
  logic [1:0]   s_awburst_i = '0, m_awburst_o, s_arburst_i = '0, m_arburst_o;
  logic [1:0]   s_awlock_i = '0, m_awlock_o, s_arlock_i = '0, m_arlock_o;
  logic [3:0]   s_awcache_i = '0, m_awcache_o, s_arcache_i = '0, m_arcache_o;
  logic [2:0]   s_awprot_i = '0, m_awprot_o, s_arprot_i = '0, m_arprot_o;
  logic         s_awvalid_i = 0, s_awready_o, m_awvalid_o, m_awready_i = 0;
  logic         s_arvalid_i = 0, s_arready_o, m_arvalid_o, m_arready_i = 0;
  logic [0:0]   s_wid_i = '0, m_wid_o;
  logic [255:0] s_wdata_i = '0, m_wdata_o;
  logic [31:0]  s_wstrb_i = '0, m_wstrb_o;
  logic         s_wlast_i = 0, m_wlast_o, s_wvalid_i = 0, s_wready_o, m_wvalid_o, m_wready_i = 0;
  logic [0:0]   m_bid_i = '0, s_bid_o;
  logic [1:0]   m_bresp_i = '0, s_bresp_o;
  logic         m_bvalid_i = 0, m_bready_o, s_bvalid_o, s_bready_i = 0;
  logic [0:0]   m_rid_i = '0, s_rid_o;
  logic [255:0] m_rdata_i = '0, s_rdata_o;
  logic [1:0]   m_rresp_i = '0, s_rresp_o;
  logic         m_rlast_i = 0, m_rvalid_i = 0, m_rready_o, s_rlast_o, s_rvalid_o, s_rready_i = 0;
  logic [1:0]   wr_cnt_o, rd_cnt_o;
  logic         wr_full_o, rd_full_o;

  axi_inflight_limiter #(.WR_MAX(W), .RD_MAX(R)) i_axi_inflight_limiter (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int mw = 0, mr = 0;
    bit aw_pend = 0, ar_pend = 0;
    logic [31:0] rnd = 32'h1234_5679;

    // R1: reset state
    #1;
    chk(wr_cnt_o == 0 && rd_cnt_o == 0, "R1", "counts in reset", {wr_cnt_o, rd_cnt_o}, 0);
    chk(!wr_full_o && !rd_full_o, "R1", "flags in reset", {wr_full_o, rd_full_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(wr_cnt_o == 0 && rd_cnt_o == 0, "R1", "counts after release", {wr_cnt_o, rd_cnt_o}, 0);

    // R8: response and last beat at zero count are ignored
    m_bvalid_i = 1; s_bready_i = 1; m_rvalid_i = 1; s_rready_i = 1; m_rlast_i = 1;
    @(negedge clk_i);
    m_bvalid_i = 0; m_rvalid_i = 0;
    chk(wr_cnt_o == 0, "R8", "wr count after response at zero", wr_cnt_o, 0);
    chk(rd_cnt_o == 0, "R8", "rd count after last beat at zero", rd_cnt_o, 0);

    // R9: payload pass-through
    s_awaddr_i = 36'hA_BCDE_F012; s_awlen_i = 4'hD; s_awcache_i = 4'h6; s_awid_i = 1'b1;
    s_araddr_i = 36'h3_0F0F_1234; s_arprot_i = 3'h5; s_arburst_i = 2'h2;
    s_wdata_i = {8{32'hDEAD_BEEF}}; s_wstrb_i = 32'hF0F0_A5A5; s_wlast_i = 1; s_wvalid_i = 1;
    m_wready_i = 1; m_bresp_i = 2'h3; m_rdata_i = {8{32'h0BAD_F00D}}; m_rresp_i = 2'h1;
    #1;
    chk(m_awaddr_o == s_awaddr_i && m_awlen_o == 4'hD && m_awcache_o == 4'h6 && m_awid_o == 1'b1,
        "R9", "aw payload", m_awaddr_o, s_awaddr_i);
    chk(m_araddr_o == s_araddr_i && m_arprot_o == 3'h5 && m_arburst_o == 2'h2,
        "R9", "ar payload", m_araddr_o, s_araddr_i);
    chk(m_wdata_o == s_wdata_i && m_wstrb_o == s_wstrb_i && m_wlast_o && m_wvalid_o && s_wready_o,
        "R9", "w channel", m_wstrb_o, s_wstrb_i);
    chk(s_bresp_o == 2'h3 && s_rdata_o == m_rdata_i && s_rresp_o == 2'h1 && m_bready_o && m_rready_o,
        "R9", "b/r channels", s_bresp_o, 3);

    // R2-R7, R10: sweep against arithmetic model
    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit aw_al, ar_al, wfire, rfire, wdec, rdec;
      @(negedge clk_i);
      rnd = nxt(rnd);
      if (!aw_pend) begin aw_pend = rnd[0] | rnd[1]; s_awaddr_i = {4'h0, rnd}; end
      if (!ar_pend) begin ar_pend = rnd[2] | rnd[3]; s_araddr_i = {rnd, 4'h0}; end
      s_awvalid_i = aw_pend; s_arvalid_i = ar_pend;
      m_awready_i = rnd[4] | rnd[5];  m_arready_i = rnd[6] | rnd[16];
      m_bvalid_i  = rnd[7] & rnd[20]; s_bready_i  = rnd[8] | rnd[9];
      m_rvalid_i  = rnd[10];          s_rready_i  = rnd[11] | rnd[12];
      m_rlast_i   = rnd[13] & rnd[14];
      #1;
      aw_al = (mw < W) || (m_bvalid_i && s_bready_i);
      ar_al = (mr < R) || (m_rvalid_i && s_rready_i && m_rlast_i);
      chk(wr_cnt_o == mw, "R2", "write count", wr_cnt_o, mw);
      chk(rd_cnt_o == mr, "R3", "read count", rd_cnt_o, mr);
      chk(wr_full_o == (mw == W), "R7", "write full flag", wr_full_o, mw == W);
      chk(rd_full_o == (mr == R), "R7", "read full flag", rd_full_o, mr == R);
      chk(m_awvalid_o == (s_awvalid_i && aw_al),
          (mw < W) ? "R4" : (aw_al ? "R6" : "R5"), "m_awvalid", m_awvalid_o, s_awvalid_i && aw_al);
      chk(s_awready_o == (m_awready_i && aw_al),
          (mw < W) ? "R4" : (aw_al ? "R6" : "R5"), "s_awready", s_awready_o, m_awready_i && aw_al);
      chk(m_arvalid_o == (s_arvalid_i && ar_al),
          (mr < R) ? "R10" : (ar_al ? "R6" : "R5"), "m_arvalid", m_arvalid_o, s_arvalid_i && ar_al);
      chk(s_arready_o == (m_arready_i && ar_al),
          (mr < R) ? "R10" : (ar_al ? "R6" : "R5"), "s_arready", s_arready_o, m_arready_i && ar_al);
      chk(m_awaddr_o == s_awaddr_i && m_araddr_o == s_araddr_i, "R9", "addr pass",
          m_awaddr_o, s_awaddr_i);
      wfire = s_awvalid_i && m_awready_i && aw_al;
      rfire = s_arvalid_i && m_arready_i && ar_al;
      wdec  = m_bvalid_i && s_bready_i && (mw != 0 || wfire);
      rdec  = m_rvalid_i && s_rready_i && m_rlast_i && (mr != 0 || rfire);
      mw = mw + int'(wfire) - int'(wdec);
      mr = mr + int'(rfire) - int'(rdec);
      chk(mw <= W && mr <= R, "R8", "model bound", mw, W);
      if (wfire) aw_pend = 0;
      if (rfire) ar_pend = 0;
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule